// File: doc/BRIEF.md
# Region Access Guard

This block decides whether a memory access may proceed by comparing its address against programmable protection regions. Instruction fetches are judged against one set of regions, and data loads and stores are judged against a second, independent set. An instruction region grants only execution. A data region grants reading, writing, or both. A fetch port and a data port each accept one request per cycle. Each port returns a registered verdict one cycle after the request: either allowed or faulted.

Regions are programmed through a simple write port. The write port selects the bank, the region index and one of three fields: base, end and permission. A build parameter fixes how the end field is read. In limit mode it is an exclusive upper address. In size mode it is a power-of-two size code, and the region is aligned to that size. Regions may overlap. When several regions match, the lowest-numbered enabled region decides. An address that no enabled region covers is refused.

Top module: `mpu_guard`

## Requirements
- R1: Fetch checks use only the instruction regions, and data checks use only the data regions. The write port selects the bank with cfgSel: 0 means instruction and 1 means data. A fetch check and a data check in the same cycle are judged independently.
- R2: When SIZE_MODE=0, a region matches an address if base <= address < end. The comparison is unsigned, and end is exclusive.
- R3: When SIZE_MODE=1, the end field holds a size code n, and the region covers 2^n bytes. Codes below 6 act as 6, and codes above ADDR_W-1 act as ADDR_W-1. The address bits below n are ignored in both the base and the address, so the region is aligned.
- R4: Bit 0 of the permission field enables the region. A disabled region never matches, even when its range covers the address.
- R5: When enabled regions overlap, the region with the lowest index alone decides the access.
- R6: An access that matches no enabled region faults.
- R7: An instruction region allows a fetch only if permission bit 1 (execute) is set.
- R8: A data region allows a read (dWrite=0) only if permission bit 1 is set, and allows a write (dWrite=1) only if permission bit 2 is set.
- R9: The valid output rises exactly one cycle after the request. The fault output is meaningful only while valid is high, and it is 0 whenever valid is low.
- R10: A configuration write in cycle N affects checks requested from cycle N+1 onward. A check requested in the same cycle as the write uses the old settings. cfgField selects the field: 0 is base, 1 is end, 2 is permission, and 3 is ignored.
- R11: Reset disables every region and drives all valid and fault outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 1 | Bank select: 0 instruction, 1 data |
| cfgIdx | input | IDX_W | Region index |
| cfgField | input | 2 | Field: 0 base, 1 end, 2 permission |
| cfgData | input | ADDR_W | Write data |
| iReq | input | 1 | Fetch check request |
| iAddr | input | ADDR_W | Fetch address |
| iValid | output | 1 | Fetch verdict valid |
| iFault | output | 1 | Fetch refused |
| dReq | input | 1 | Data check request |
| dAddr | input | ADDR_W | Data address |
| dWrite | input | 1 | 1 for store, 0 for load |
| dValid | output | 1 | Data verdict valid |
| dFault | output | 1 | Data access refused |

## Verification
A configuration write and a check of the region being written can happen in the same cycle. To provoke this, the bench enables a region with cfgWe while it requests a fetch inside that region. The verdict must reflect the old, disabled setting and therefore fault. A repeat of the same fetch in the following cycle must be allowed. A fetch check and a data check are also raised together on one address that only a data region covers, and the two verdicts must differ.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
  // Field codes on the configuration port
  localparam logic [1:0] FLD_BASE = 2'd0;
  localparam logic [1:0] FLD_END  = 2'd1;
  localparam logic [1:0] FLD_PERM = 2'd2;

  // Strobes from control to datapath
  typedef struct packed {
    logic toData;
    logic baseWe;
    logic endWe;
    logic permWe;
  } cfgStrobe_t;
endpackage

// File: rtl/mpu_ctrl.sv
module mpu_ctrl
  import mpu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWe,
  input  logic       cfgSel,
  input  logic [1:0] cfgField,
  input  logic       iReq,
  input  logic       dReq,
  output cfgStrobe_t strobe,
  output logic       iValid,
  output logic       dValid
);
  always_comb begin
    strobe        = '0;
    strobe.toData = cfgSel;
    strobe.baseWe = cfgWe && (cfgField == FLD_BASE);
    strobe.endWe  = cfgWe && (cfgField == FLD_END);
    strobe.permWe = cfgWe && (cfgField == FLD_PERM);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      iValid <= 1'b0;
      dValid <= 1'b0;
    end else begin
      iValid <= iReq;
      dValid <= dReq;
    end
  end

  // R9: verdict valid follows the request by exactly one cycle
  a_r9_ivalid_follows: assert property (@(posedge clk) disable iff (!rstN)
    iReq |=> iValid);
  a_r9_dvalid_follows: assert property (@(posedge clk) disable iff (!rstN)
    dReq |=> dValid);
  a_r9_ivalid_idle: assert property (@(posedge clk) disable iff (!rstN)
    !iReq |=> !iValid);
endmodule

// File: rtl/mpu_region_set.sv
module mpu_region_set #(
  parameter int ADDR_W    = 32,
  parameter int NUM_REG   = 8,
  parameter int IDX_W     = 3,
  parameter bit SIZE_MODE = 1'b0,
  parameter bit IS_DATA   = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baseWe,
  input  logic              endWe,
  input  logic              permWe,
  input  logic [IDX_W-1:0]  wIdx,
  input  logic [ADDR_W-1:0] wData,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic              write,
  input  logic              outValid,
  output logic              fault
);
  localparam int MIN_SHIFT = 6;
  localparam int MAX_SHIFT = ADDR_W - 1;

  logic [ADDR_W-1:0] baseQ [NUM_REG];
  logic [ADDR_W-1:0] endQ  [NUM_REG];
  logic [2:0]        permQ [NUM_REG];
  logic [NUM_REG-1:0] hitVec;
  logic allowNow;
  logic idxOk;

  assign idxOk = int'(wIdx) < NUM_REG;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_REG; k++) begin
        baseQ[k] <= '0;
        endQ[k]  <= '0;
        permQ[k] <= '0;
      end
    end else if (idxOk) begin
      if (baseWe) baseQ[wIdx] <= wData;
      if (endWe)  endQ[wIdx]  <= wData;
      if (permWe) permQ[wIdx] <= wData[2:0];
    end
  end

  for (genvar k = 0; k < NUM_REG; k++) begin : g_match
    if (SIZE_MODE) begin : g_size
      logic [ADDR_W-1:0] mask;
      always_comb begin
        int sh;
        if (endQ[k] < ADDR_W'(MIN_SHIFT))      sh = MIN_SHIFT;
        else if (endQ[k] > ADDR_W'(MAX_SHIFT)) sh = MAX_SHIFT;
        else                                   sh = int'(endQ[k]);
        mask = {ADDR_W{1'b1}} << sh;
      end
      assign hitVec[k] = permQ[k][0] && ((addr & mask) == (baseQ[k] & mask));
    end else begin : g_limit
      assign hitVec[k] = permQ[k][0] && (addr >= baseQ[k]) && (addr < endQ[k]);
    end
  end

  // Scan downward so the lowest matching index has the final say
  always_comb begin
    allowNow = 1'b0;
    for (int k = NUM_REG - 1; k >= 0; k--) begin
      if (hitVec[k]) begin
        if (IS_DATA) allowNow = write ? permQ[k][2] : permQ[k][1];
        else         allowNow = permQ[k][1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) fault <= 1'b0;
    else       fault <= req && !allowNow;
  end

  // R9: a fault is only reported alongside a valid verdict
  a_r9_fault_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> outValid);
  // R6: a request covered by no enabled region is refused
  a_r6_nohit_faults: assert property (@(posedge clk) disable iff (!rstN)
    (req && (hitVec == '0)) |=> fault);
endmodule

// File: rtl/mpu_dpath.sv
module mpu_dpath
  import mpu_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_IREG  = 8,
  parameter int NUM_DREG  = 8,
  parameter int IDX_W     = 3,
  parameter bit SIZE_MODE = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        strobe,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic              iReq,
  input  logic [ADDR_W-1:0] iAddr,
  input  logic              dReq,
  input  logic [ADDR_W-1:0] dAddr,
  input  logic              dWrite,
  input  logic              iValid,
  input  logic              dValid,
  output logic              iFault,
  output logic              dFault
);
  logic              reqB   [2];
  logic [ADDR_W-1:0] addrB  [2];
  logic              writeB [2];
  logic              validB [2];
  logic              faultB [2];

  assign reqB[0] = iReq;  assign addrB[0] = iAddr; assign writeB[0] = 1'b0;   assign validB[0] = iValid;
  assign reqB[1] = dReq;  assign addrB[1] = dAddr; assign writeB[1] = dWrite; assign validB[1] = dValid;
  assign iFault = faultB[0];
  assign dFault = faultB[1];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic sel;
    assign sel = (strobe.toData == b[0]);
    mpu_region_set #(
      .ADDR_W   (ADDR_W),
      .NUM_REG  (b == 0 ? NUM_IREG : NUM_DREG),
      .IDX_W    (IDX_W),
      .SIZE_MODE(SIZE_MODE),
      .IS_DATA  (b == 1)
    ) u_set (
      .clk     (clk),
      .rstN    (rstN),
      .baseWe  (sel && strobe.baseWe),
      .endWe   (sel && strobe.endWe),
      .permWe  (sel && strobe.permWe),
      .wIdx    (cfgIdx),
      .wData   (cfgData),
      .req     (reqB[b]),
      .addr    (addrB[b]),
      .write   (writeB[b]),
      .outValid(validB[b]),
      .fault   (faultB[b])
    );
  end
endmodule

// File: rtl/mpu_guard.sv
module mpu_guard #(
  parameter int ADDR_W    = 32,
  parameter int NUM_IREG  = 8,   // up to 32
  parameter int NUM_DREG  = 8,   // up to 32
  parameter bit SIZE_MODE = 1'b0,
  localparam int NUM_MAX  = (NUM_IREG > NUM_DREG) ? NUM_IREG : NUM_DREG,
  localparam int IDX_W    = (NUM_MAX > 1) ? $clog2(NUM_MAX) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic              cfgSel,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [1:0]        cfgField,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic              iReq,
  input  logic [ADDR_W-1:0] iAddr,
  output logic              iValid,
  output logic              iFault,
  input  logic              dReq,
  input  logic [ADDR_W-1:0] dAddr,
  input  logic              dWrite,
  output logic              dValid,
  output logic              dFault
);
  mpu_pkg::cfgStrobe_t strobe;

  mpu_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgField(cfgField),
    .iReq(iReq), .dReq(dReq), .strobe(strobe), .iValid(iValid), .dValid(dValid)
  );

  mpu_dpath #(
    .ADDR_W(ADDR_W), .NUM_IREG(NUM_IREG), .NUM_DREG(NUM_DREG),
    .IDX_W(IDX_W), .SIZE_MODE(SIZE_MODE)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgIdx(cfgIdx), .cfgData(cfgData),
    .iReq(iReq), .iAddr(iAddr), .dReq(dReq), .dAddr(dAddr), .dWrite(dWrite),
    .iValid(iValid), .dValid(dValid), .iFault(iFault), .dFault(dFault)
  );
endmodule

// File: tb/mpu_guard_tb.sv
module mpu_guard_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0, cfgSel = 1'b0;
  logic [2:0] cfgIdx = '0;
  logic [1:0] cfgField = '0;
  logic [31:0] cfgData = '0;
  logic iReq = 1'b0, dReq = 1'b0, dWrite = 1'b0;
  logic [31:0] iAddr = '0, dAddr = '0;
  logic iValid, iFault, dValid, dFault;
  logic iValidS, iFaultS, dValidS, dFaultS;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mpu_guard #(.SIZE_MODE(1'b0)) u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgIdx(cfgIdx),
    .cfgField(cfgField), .cfgData(cfgData), .iReq(iReq), .iAddr(iAddr),
    .iValid(iValid), .iFault(iFault), .dReq(dReq), .dAddr(dAddr), .dWrite(dWrite),
    .dValid(dValid), .dFault(dFault));

  mpu_guard #(.SIZE_MODE(1'b1)) u_dut_sz (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgIdx(cfgIdx),
    .cfgField(cfgField), .cfgData(cfgData), .iReq(iReq), .iAddr(iAddr),
    .iValid(iValidS), .iFault(iFaultS), .dReq(dReq), .dAddr(dAddr), .dWrite(dWrite),
    .dValid(dValidS), .dFault(dFaultS));

  typedef struct packed {
    logic        isData;
    logic        wr;
    logic [31:0] addr;
    logic        expFault;
  } vec_t;

  // Limit-mode vectors: covers R1 R2 R5 R6 R7 R8
  localparam int NVEC = 16;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 32'h0000_1000, 1'b0},  // R2 base inclusive
    '{1'b0, 1'b0, 32'h0000_1FFF, 1'b0},  // R5 I0 beats I1
    '{1'b0, 1'b0, 32'h0000_0FFF, 1'b1},  // R6 below
    '{1'b0, 1'b0, 32'h0000_2000, 1'b1},  // R7 I1 no exec
    '{1'b0, 1'b0, 32'h0000_2FFF, 1'b1},
    '{1'b0, 1'b0, 32'h0000_3000, 1'b1},  // R2 end exclusive
    '{1'b0, 1'b0, 32'h0000_4800, 1'b1},  // R4 disabled
    '{1'b0, 1'b0, 32'h0000_8000, 1'b1},  // R1 data region only
    '{1'b1, 1'b0, 32'h0000_8000, 1'b0},  // R8 read ok
    '{1'b1, 1'b1, 32'h0000_8100, 1'b1},  // R5 D0 read-only wins
    '{1'b1, 1'b1, 32'h0000_9100, 1'b0},  // R8 D1 write ok
    '{1'b1, 1'b0, 32'h0000_9FFF, 1'b0},
    '{1'b1, 1'b0, 32'h0000_A000, 1'b1},  // R2 end exclusive
    '{1'b1, 1'b1, 32'h0000_0080, 1'b0},  // R8 write-only region
    '{1'b1, 1'b0, 32'h0000_0080, 1'b1},  // R8 read refused
    '{1'b1, 1'b1, 32'h0000_7FFF, 1'b1}   // R6 gap
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic sel, input int idx, input logic [1:0] fld, input logic [31:0] val);
    cfgWe = 1'b1; cfgSel = sel; cfgIdx = 3'(idx); cfgField = fld; cfgData = val;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic region(input logic sel, input int idx, input logic [31:0] b,
                        input logic [31:0] e, input logic [31:0] p);
    cfg(sel, idx, 2'd0, b);
    cfg(sel, idx, 2'd1, e);
    cfg(sel, idx, 2'd2, p);
  endtask

  // Issue one check, sample verdict after the registering edge
  task automatic probe(input logic isData, input logic wr, input logic [31:0] a,
                       output logic v, output logic f, input logic szDut);
    if (isData) begin dReq = 1'b1; dAddr = a; dWrite = wr; end
    else begin iReq = 1'b1; iAddr = a; end
    @(negedge clk);
    if (szDut) begin v = isData ? dValidS : iValidS; f = isData ? dFaultS : iFaultS; end
    else       begin v = isData ? dValid  : iValid;  f = isData ? dFault  : iFault;  end
    iReq = 1'b0; dReq = 1'b0; dWrite = 1'b0;
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic v, f;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 iValid reset", iValid, 1'b0);
    chk("R11 dFault reset", dFault, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    probe(1'b0, 1'b0, 32'h1000, v, f, 1'b0);
    chk("R9 valid one cycle later", v, 1'b1);
    chk("R11 all regions disabled after reset", f, 1'b1);
    @(negedge clk);
    chk("R9 valid low when idle", iValid, 1'b0);
    chk("R9 fault low when idle", iFault, 1'b0);

    region(1'b0, 0, 32'h1000, 32'h2000, 32'h3);
    region(1'b0, 1, 32'h1800, 32'h3000, 32'h1);
    region(1'b0, 2, 32'h4000, 32'h5000, 32'h2);
    region(1'b1, 0, 32'h8000, 32'h9000, 32'h3);
    region(1'b1, 1, 32'h8000, 32'hA000, 32'h7);
    region(1'b1, 7, 32'h0000, 32'h0100, 32'h5);
    cfg(1'b1, 7, 2'd3, 32'hFFFF_FFFF);   // R10 field code 3 ignored

    for (int n = 0; n < NVEC; n++) begin
      probe(VECS[n].isData, VECS[n].wr, VECS[n].addr, v, f, 1'b0);
      chk($sformatf("R2 vector %0d valid", n), v, 1'b1);
      chk($sformatf("R5 vector %0d verdict", n), f, VECS[n].expFault);
    end

    // R10: write and check in the same cycle, old setting applies
    cfgWe = 1'b1; cfgSel = 1'b0; cfgIdx = 3'd2; cfgField = 2'd2; cfgData = 32'h3;
    iReq = 1'b1; iAddr = 32'h4800;
    @(negedge clk);
    cfgWe = 1'b0; iReq = 1'b0;
    chk("R10 same-cycle write uses old setting", iFault, 1'b1);
    probe(1'b0, 1'b0, 32'h4800, v, f, 1'b0);
    chk("R10 write effective next check", f, 1'b0);

    // R1: fetch and data checks together on a data-only address
    iReq = 1'b1; iAddr = 32'h8000; dReq = 1'b1; dAddr = 32'h8000; dWrite = 1'b0;
    @(negedge clk);
    iReq = 1'b0; dReq = 1'b0;
    chk("R1 fetch refused on data region", iFault, 1'b1);
    chk("R1 data read allowed same cycle", dFault, 1'b0);
    chk("R1 both valid", iValid & dValid, 1'b1);

    // R4: disable I0, overlap falls through to I1 (no exec)
    cfg(1'b0, 0, 2'd2, 32'h2);
    probe(1'b0, 1'b0, 32'h1000, v, f, 1'b0);
    chk("R4 disabled region does not match", f, 1'b1);
    probe(1'b0, 1'b0, 32'h1900, v, f, 1'b0);
    chk("R4 next region decides", f, 1'b1);

    // R3: size mode, fresh reset
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    region(1'b0, 0, 32'h0001_0040, 32'd8, 32'h3);
    region(1'b1, 0, 32'h0000_0200, 32'd2, 32'h3);
    probe(1'b0, 1'b0, 32'h0001_0000, v, f, 1'b1);
    chk("R3 base low bits ignored", f, 1'b0);
    probe(1'b0, 1'b0, 32'h0001_00FF, v, f, 1'b1);
    chk("R3 last byte of 256", f, 1'b0);
    probe(1'b0, 1'b0, 32'h0001_0100, v, f, 1'b1);
    chk("R3 past 256 bytes", f, 1'b1);
    probe(1'b1, 1'b0, 32'h0000_023F, v, f, 1'b1);
    chk("R3 small code acts as 64", f, 1'b0);
    probe(1'b1, 1'b0, 32'h0000_0240, v, f, 1'b1);
    chk("R3 past 64 bytes", f, 1'b1);
    probe(1'b1, 1'b1, 32'h0000_0200, v, f, 1'b1);
    chk("R8 write without write bit", f, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule